// File: doc/BRIEF.md
# Microcoded Control Sequencer with Call Stack

This block is the control core of a small processor. It holds its program of control words in an internal code memory, which is written through a simple load port. Once a start pulse arrives it fetches codes from address 0. Each code goes into a code register and is decoded there. A micro-operation code drives an enable bus and an argument bus for the datapath units. Other codes change the flow of execution: unconditional and conditional jumps, subroutine calls and returns, updates of an external data pointer, and halt.

A code is one, two or three words long. The two most significant bits of its first word give the length. After each code the state counter moves past all of the code's words, unless the code redirects execution. Conditional jumps test a zero flag and a carry flag that the integer unit supplies. Calls push their return address onto a small last-in first-out stack and returns pop it. A push onto a full stack, or a pop from an empty one, sets a sticky error flag.

Top module: `usq_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle: `running`=0, `sc_addr`=0, `uop_valid`=0, `xptr`=0 and `stk_err`=0.
- R2: A `start` pulse sets the state counter to 0 and begins fetching there. Every code takes two cycles. In the first cycle (fetch) `uop_valid` is 0. In the second cycle (execute) the code is decoded, and `sc_addr` shows the address of that code during both cycles.
- R3: Bits [15:14] of the first word give the length: 01=1, 10=2, 11=3 (00 counts as 1). Bits [13:10] give the opcode: 0 micro-op, 1 jump, 2 jump-if-zero, 3 jump-if-carry, 4 call, 5 return, 6 load pointer, 7 increment pointer, 8 halt. A code that does not redirect execution advances the counter by its length.
- R4: A micro-op code raises `uop_valid` for its execute cycle. At the same time `uop_en` carries bits [9:0] of its first word, and `uop_arg` carries 0 (length 1), the second word (length 2), or {third word, second word} (length 3). No other opcode raises `uop_valid`.
- R5: A jump loads the counter with the low 8 bits of its second word.
- R6: Jump-if-zero and jump-if-carry behave as a jump when `zf` or `cf` respectively is 1. Otherwise execution continues with the next sequential code.
- R7: A call pushes its own address plus its length and then jumps. A return pops that address into the counter.
- R8: Nested calls return in last-in first-out order, up to a depth of `STK_DEPTH` (4).
- R9: A call with a full stack still jumps but pushes nothing. A return with an empty stack continues sequentially. Both set `stk_err`, which stays 1 until the next reset or start.
- R10: A load-pointer code sets `xptr` to its second word, and an increment-pointer code adds 1 to it. A start clears `xptr`.
- R11: A halt code clears `running`, and no further code is executed until the next `start`. That start restarts from address 0.
- R12: A write on the load port stores `ld_data` at `ld_addr`, and the next run fetches the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart pulse: counter, pointer, stack and error cleared |
| ld_en | input | 1 | Code memory write enable |
| ld_addr | input | 8 | Code memory write address |
| ld_data | input | 16 | Code memory write data |
| zf | input | 1 | Zero flag from the integer unit |
| cf | input | 1 | Carry flag from the integer unit |
| running | output | 1 | High between start and halt |
| sc_addr | output | 8 | State counter (address of the current code) |
| uop_valid | output | 1 | Micro-op issued this cycle |
| uop_en | output | 10 | Micro-operation enables |
| uop_arg | output | 32 | Micro-op argument from the operand words |
| xptr | output | 16 | External data address pointer |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The first program is a straight line of micro-ops of length 1, 2 and 3 mixed with pointer codes. It separates the step of the counter from the argument assembly, and it also shows that non-micro codes stay silent on the bus. One branch program runs twice with opposite flag settings, so a swapped zero/carry test or an inverted condition shows up as a wrong or skipped micro-op address. A single call/return pair tests the return-address arithmetic. A five-deep call chain returning through four slots and then one more return tests last-in first-out order, the overflow rule and the underflow rule together. A final short program written over address 0 confirms the restart, the reload and the clearing of the error flag.

// File: rtl/usq_pkg.sv
package usq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC} seq_state_e;

  typedef enum logic [3:0] {
    OP_MICRO = 4'd0,
    OP_JMP   = 4'd1,
    OP_JZ    = 4'd2,
    OP_JC    = 4'd3,
    OP_CALL  = 4'd4,
    OP_RET   = 4'd5,
    OP_SETX  = 4'd6,
    OP_INCX  = 4'd7,
    OP_HALT  = 4'd8
  } op_e;

  // length field to word count; the unused encoding 00 counts as one word
  function automatic logic [1:0] code_words(input logic [1:0] fld);
    return (fld == 2'b00) ? 2'd1 : fld;
  endfunction
endpackage

// File: rtl/usq_codemem.sv
module usq_codemem #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_w0,
  output logic [WORD_W-1:0] rd_w1,
  output logic [WORD_W-1:0] rd_w2
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] a1, a2;

  assign a1 = rd_addr + ADDR_W'(1);
  assign a2 = rd_addr + ADDR_W'(2);

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
  end

  // all three candidate words land in the code register together
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_w0 <= mem[rd_addr];
      rd_w1 <= mem[a1];
      rd_w2 <= mem[a2];
    end
  end
endmodule

// File: rtl/usq_stack.sv
module usq_stack #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic                       pop,
  input  logic [ADDR_W-1:0]          push_data,
  output logic [ADDR_W-1:0]          top_data,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] slots [DEPTH];
  logic [LVL_W-1:0]  below;

  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);
  assign below    = level - LVL_W'(1);
  assign top_data = empty ? '0 : slots[below[IDX_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (clr) begin
      level <= '0;
    end else if (push && !full) begin
      slots[level[IDX_W-1:0]] <= push_data;
      level <= level + LVL_W'(1);
    end else if (pop && !empty) begin
      level <= below;
    end
  end
endmodule

// File: rtl/usq_decode.sv
module usq_decode
  import usq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8,
  parameter int UOP_W  = WORD_W - 6
) (
  input  logic [WORD_W-1:0]   w0,
  input  logic [WORD_W-1:0]   w1,
  input  logic [WORD_W-1:0]   w2,
  input  logic                zf,
  input  logic                cf,
  input  logic [ADDR_W-1:0]   cur_addr,
  output logic [1:0]          len,
  output logic [ADDR_W-1:0]   seq_addr,
  output logic [ADDR_W-1:0]   target,
  output logic                taken,
  output logic                is_micro,
  output logic                is_call,
  output logic                is_ret,
  output logic                is_setx,
  output logic                is_incx,
  output logic                is_halt,
  output logic [UOP_W-1:0]    en_bits,
  output logic [2*WORD_W-1:0] arg
);
  op_e op;

  assign op       = op_e'(w0[WORD_W-3 -: 4]);
  assign len      = code_words(w0[WORD_W-1 -: 2]);
  assign seq_addr = cur_addr + {{(ADDR_W-2){1'b0}}, len};
  assign target   = w1[ADDR_W-1:0];
  assign en_bits  = w0[UOP_W-1:0];

  assign is_micro = (op == OP_MICRO);
  assign is_call  = (op == OP_CALL);
  assign is_ret   = (op == OP_RET);
  assign is_setx  = (op == OP_SETX);
  assign is_incx  = (op == OP_INCX);
  assign is_halt  = (op == OP_HALT);

  always_comb begin
    case (op)
      OP_JMP, OP_CALL: taken = 1'b1;
      OP_JZ:           taken = zf;
      OP_JC:           taken = cf;
      default:         taken = 1'b0;
    endcase
  end

  always_comb begin
    case (len)
      2'd2:    arg = {{WORD_W{1'b0}}, w1};
      2'd3:    arg = {w2, w1};
      default: arg = '0;
    endcase
  end
endmodule

// File: rtl/usq_sequencer.sv
module usq_sequencer
  import usq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int STK_DEPTH = 4,
  localparam int UOP_W    = WORD_W - 6,
  localparam int LVL_W    = $clog2(STK_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                ld_en,
  input  logic [ADDR_W-1:0]   ld_addr,
  input  logic [WORD_W-1:0]   ld_data,
  input  logic                zf,
  input  logic                cf,
  output logic                running,
  output logic [ADDR_W-1:0]   sc_addr,
  output logic                uop_valid,
  output logic [UOP_W-1:0]    uop_en,
  output logic [2*WORD_W-1:0] uop_arg,
  output logic [WORD_W-1:0]   xptr,
  output logic                stk_err
);
  seq_state_e state;
  logic [WORD_W-1:0] ir0, ir1, ir2;

  logic [1:0]          d_len;
  logic [ADDR_W-1:0]   d_seq, d_target, stk_top, next_addr;
  logic                d_taken, d_micro, d_call, d_ret, d_setx, d_incx, d_halt;
  logic [UOP_W-1:0]    d_en;
  logic [2*WORD_W-1:0] d_arg;

  // named events, observed by the bound checker
  logic in_fetch, in_exec, push_req, pop_req, ret_ok, redirect;
  logic stk_full, stk_empty;
  logic [LVL_W-1:0] stk_level;

  assign in_fetch = (state == ST_FETCH);
  assign in_exec  = (state == ST_EXEC);
  assign running  = (state != ST_IDLE);
  assign push_req = in_exec && d_call;
  assign pop_req  = in_exec && d_ret;
  assign ret_ok   = pop_req && !stk_empty;
  assign redirect = in_exec && (d_taken || ret_ok);

  usq_codemem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_mem (
    .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_en(in_fetch), .rd_addr(sc_addr),
    .rd_w0(ir0), .rd_w1(ir1), .rd_w2(ir2)
  );

  usq_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .UOP_W(UOP_W)) i_dec (
    .w0(ir0), .w1(ir1), .w2(ir2), .zf(zf), .cf(cf), .cur_addr(sc_addr),
    .len(d_len), .seq_addr(d_seq), .target(d_target), .taken(d_taken),
    .is_micro(d_micro), .is_call(d_call), .is_ret(d_ret), .is_setx(d_setx),
    .is_incx(d_incx), .is_halt(d_halt), .en_bits(d_en), .arg(d_arg)
  );

  usq_stack #(.ADDR_W(ADDR_W), .DEPTH(STK_DEPTH)) i_stk (
    .clk(clk), .rst_n(rst_n), .clr(start), .push(push_req), .pop(pop_req),
    .push_data(d_seq), .top_data(stk_top), .full(stk_full),
    .empty(stk_empty), .level(stk_level)
  );

  always_comb begin
    if (d_taken)     next_addr = d_target;
    else if (ret_ok) next_addr = stk_top;
    else             next_addr = d_seq;
  end

  assign uop_valid = in_exec && d_micro;
  assign uop_en    = uop_valid ? d_en  : '0;
  assign uop_arg   = uop_valid ? d_arg : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sc_addr <= '0;
      xptr    <= '0;
      stk_err <= 1'b0;
    end else if (start) begin
      state   <= ST_FETCH;
      sc_addr <= '0;
      xptr    <= '0;
      stk_err <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: state <= ST_EXEC;
        ST_EXEC: begin
          sc_addr <= next_addr;
          state   <= d_halt ? ST_IDLE : ST_FETCH;
          if (d_setx)      xptr <= ir1;
          else if (d_incx) xptr <= xptr + WORD_W'(1);
          if ((push_req && stk_full) || (pop_req && stk_empty)) stk_err <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usq_checker.sv
module usq_checker #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              running,
  input logic              in_fetch,
  input logic              in_exec,
  input logic              redirect,
  input logic              d_taken,
  input logic              d_halt,
  input logic [1:0]        d_len,
  input logic [ADDR_W-1:0] d_target,
  input logic [ADDR_W-1:0] sc_addr,
  input logic              uop_valid,
  input logic              push_req,
  input logic              stk_full,
  input logic              stk_err,
  input logic [LVL_W-1:0]  stk_level
);
  logic [ADDR_W-1:0] len_ext;
  assign len_ext = {{(ADDR_W-2){1'b0}}, d_len};

  p_start_fetch0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (sc_addr == '0 && in_fetch && !uop_valid));

  p_fetch_then_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fetch && !start) |=> in_exec);

  p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && !redirect && !start) |=> sc_addr == $past(sc_addr) + $past(len_ext));

  p_uop_in_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> in_exec);

  p_jump_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && d_taken && !start) |=> sc_addr == $past(d_target));

  p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(stk_level) <= DEPTH);

  p_overflow_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && stk_full && !start) |=> stk_err);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_err && !start) |=> stk_err);

  p_halt_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && d_halt && !start) |=> !running);
endmodule

bind usq_sequencer usq_checker #(.ADDR_W(ADDR_W), .DEPTH(STK_DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .running(running),
  .in_fetch(in_fetch), .in_exec(in_exec), .redirect(redirect),
  .d_taken(d_taken), .d_halt(d_halt), .d_len(d_len), .d_target(d_target),
  .sc_addr(sc_addr), .uop_valid(uop_valid), .push_req(push_req),
  .stk_full(stk_full), .stk_err(stk_err), .stk_level(stk_level)
);

// File: tb/test_usq_sequencer.sv
module test_usq_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        zf = 1'b0, cf = 1'b0;
  logic        running, uop_valid, stk_err;
  logic [7:0]  sc_addr;
  logic [9:0]  uop_en;
  logic [31:0] uop_arg;
  logic [15:0] xptr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    logic [7:0]  addr;
    logic [9:0]  en;
    logic [31:0] arg;
    string       tag;
  } uop_item_t;
  uop_item_t expq[$];

  always #5 clk = ~clk;

  usq_sequencer i_usq_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .zf(zf), .cf(cf), .running(running), .sc_addr(sc_addr),
    .uop_valid(uop_valid), .uop_en(uop_en), .uop_arg(uop_arg), .xptr(xptr),
    .stk_err(stk_err)
  );

  // first word: [15:14] length, [13:10] opcode, [9:0] enables
  function automatic logic [15:0] cw(input int len, input int op, input int en);
    return {2'(len), 4'(op), 10'(en)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 8'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic expect_uop(input int a, input int en, input logic [31:0] arg,
                            input string tag);
    uop_item_t it;
    it.addr = 8'(a); it.en = 10'(en); it.arg = arg; it.tag = tag;
    expq.push_back(it);
  endtask

  // start, check the fetch cycle, wait for halt
  task automatic run_prog();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(running && !uop_valid && sc_addr == 8'h00, "R2", "fetch cycle at address 0",
          {running, uop_valid, sc_addr}, {1'b1, 1'b0, 8'h00});
    for (int i = 0; i < 2000 && running; i++) @(negedge clk);
    check(!running, "R11", "halted", running, 0);
    check(expq.size() == 0, "R4", "pending expected micro-ops", expq.size(), 0);
    expq.delete();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && uop_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R4", "unexpected micro-op at", sc_addr, 0);
      end else begin
        uop_item_t it;
        it = expq.pop_front();
        check(sc_addr == it.addr && uop_en == it.en && uop_arg == it.arg, it.tag,
              "micro-op addr/en/arg", {sc_addr, uop_en, uop_arg}, {it.addr, it.en, it.arg});
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        check(1'b0, "WDOG", "watchdog expired", cycles, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!running && sc_addr == 0 && !uop_valid && xptr == 0 && !stk_err, "R1",
          "state in reset", {running, sc_addr, uop_valid, xptr, stk_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!running && sc_addr == 0 && !uop_valid && xptr == 0 && !stk_err, "R1",
          "state after reset", {running, sc_addr, uop_valid, xptr, stk_err}, 0);

    // straight line: lengths 1/2/3 and pointer codes
    wr(0, cw(1, 0, 'h011));
    wr(1, cw(2, 0, 'h022)); wr(2, 16'hABCD);
    wr(3, cw(3, 0, 'h033)); wr(4, 16'h5678); wr(5, 16'h1234);
    wr(6, cw(2, 6, 0));     wr(7, 16'h0100);
    wr(8, cw(1, 7, 0));
    wr(9, cw(1, 7, 0));
    wr(10, cw(1, 0, 'h044));
    wr(11, cw(1, 8, 0));
    expect_uop(0, 'h011, 32'h0, "R3");
    expect_uop(1, 'h022, 32'h0000ABCD, "R4");
    expect_uop(3, 'h033, 32'h12345678, "R4");
    expect_uop(10, 'h044, 32'h0, "R3");
    run_prog();
    check(xptr == 16'h0102, "R10", "pointer after load and two increments", xptr, 16'h0102);
    check(!stk_err, "R9", "no error on straight line", stk_err, 0);
    repeat (20) @(negedge clk);
    check(!running && !uop_valid, "R11", "quiet after halt", {running, uop_valid}, 0);

    // conditional jumps, both flag settings
    wr(0, cw(2, 1, 0)); wr(1, 16'd20);
    wr(20, cw(2, 3, 0)); wr(21, 16'd40);
    wr(22, cw(1, 0, 'h051));
    wr(23, cw(2, 2, 0)); wr(24, 16'd30);
    wr(25, cw(1, 0, 'h0EE));
    wr(26, cw(1, 8, 0));
    wr(30, cw(1, 0, 'h052));
    wr(31, cw(1, 8, 0));
    wr(40, cw(1, 0, 'h053));
    wr(41, cw(1, 8, 0));
    zf = 1'b1; cf = 1'b0;
    expect_uop(22, 'h051, 0, "R6");
    expect_uop(30, 'h052, 0, "R5");
    run_prog();
    zf = 1'b0; cf = 1'b1;
    expect_uop(40, 'h053, 0, "R6");
    run_prog();
    zf = 1'b0; cf = 1'b0;
    expect_uop(22, 'h051, 0, "R6");
    expect_uop(25, 'h0EE, 0, "R6");
    run_prog();

    // single call and return
    wr(0, cw(2, 1, 0)); wr(1, 16'd70);
    wr(70, cw(2, 4, 0)); wr(71, 16'd90);
    wr(72, cw(1, 0, 'h061));
    wr(73, cw(1, 8, 0));
    wr(90, cw(1, 0, 'h062));
    wr(91, cw(1, 5, 0));
    expect_uop(90, 'h062, 0, "R7");
    expect_uop(72, 'h061, 0, "R7");
    run_prog();
    check(!stk_err, "R7", "balanced call/return leaves no error", stk_err, 0);

    // five-deep chain: overflow then underflow
    wr(0, cw(2, 1, 0)); wr(1, 16'd100);
    wr(100, cw(2, 4, 0)); wr(101, 16'd110);
    wr(110, cw(2, 4, 0)); wr(111, 16'd120);
    wr(120, cw(2, 4, 0)); wr(121, 16'd130);
    wr(130, cw(2, 4, 0)); wr(131, 16'd140);
    wr(140, cw(2, 4, 0)); wr(141, 16'd150);
    wr(150, cw(1, 0, 'h070)); wr(151, cw(1, 5, 0));
    wr(132, cw(1, 0, 'h074)); wr(133, cw(1, 5, 0));
    wr(122, cw(1, 0, 'h073)); wr(123, cw(1, 5, 0));
    wr(112, cw(1, 0, 'h072)); wr(113, cw(1, 5, 0));
    wr(102, cw(1, 0, 'h071)); wr(103, cw(1, 5, 0));
    wr(104, cw(1, 0, 'h079)); wr(105, cw(1, 8, 0));
    expect_uop(150, 'h070, 0, "R9");
    expect_uop(132, 'h074, 0, "R8");
    expect_uop(122, 'h073, 0, "R8");
    expect_uop(112, 'h072, 0, "R8");
    expect_uop(102, 'h071, 0, "R8");
    expect_uop(104, 'h079, 0, "R9");
    run_prog();
    check(stk_err, "R9", "error after overflow and underflow", stk_err, 1);
    repeat (5) @(negedge clk);
    check(stk_err, "R9", "error flag sticky while idle", stk_err, 1);

    // reload address 0 and restart
    wr(0, cw(1, 0, 'h07A));
    wr(1, cw(1, 8, 0));
    expect_uop(0, 'h07A, 0, "R12");
    run_prog();
    check(!stk_err, "R9", "start clears error", stk_err, 0);
    check(xptr == 0, "R10", "start clears pointer", xptr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule